// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller sits between a fixed set of interrupt sources and a processor core. It latches a request when a source input rises, and a per-source enable from software can hold that request back. Among the requests that may be served, it offers the most urgent one to the core as a vector index. The core accepts the offer by pulsing an acknowledge. Source 0 is the most urgent, and urgency falls as the index rises.

The block keeps one "active level" bit per source. The bit for a source is set while that source's service routine runs. The set bits act as a temporary mask: only a source more urgent than every active routine can be offered. A global nesting switch decides whether an active routine may be preempted at all. A return strobe from the core ends the innermost routine, which is the most urgent active one. Requests that lose out stay latched and are offered in order of urgency once the routines above them have returned.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it, `irq_req_o` is 0, `active_o` is all zeros and `pend_o` is all zeros.
- R2: A 0-to-1 change on `src_i[k]` sets `pend_o[k]` on the following clock edge. A source held high after its request was cleared does not set the bit again. A second rising edge while the bit is already set still leaves exactly one pending request.
- R3: A pending source whose `umask_i` bit is 0 is never offered, and its `pend_o` bit stays set.
- R4: When several sources are eligible, the one with the lowest index is offered on `irq_vec_o`.
- R5: Once `irq_req_o` is high, it and `irq_vec_o` hold their values until a cycle with `ack_i` high. The cycle after that acknowledge, `irq_req_o` is 0.
- R6: An acknowledge while `irq_req_o` is high clears `pend_o[irq_vec_o]` and sets `active_o[irq_vec_o]` on the same clock edge.
- R7: With `nest_en_i` = 1, a pending source is eligible only if its index is strictly lower than every set bit of `active_o`. Such a source is offered while a less urgent routine is active.
- R8: With `nest_en_i` = 0, no request is offered while any bit of `active_o` is set.
- R9: A pulse on `rti_i` clears the lowest-index set bit of `active_o`. A pulse while `active_o` is all zeros changes nothing.
- R10: A request that was blocked by an active routine stays pending and is offered, in urgency order, once the blocking routines have returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Source request lines, latched on a rising edge |
| umask_i | input | N_SRC | Per-source enable, 1 = may be offered |
| nest_en_i | input | 1 | 1 = a more urgent request may preempt an active routine |
| ack_i | input | 1 | Core accepts the offered vector |
| rti_i | input | 1 | Core returns from the innermost routine |
| irq_req_o | output | 1 | Request offered to the core |
| irq_vec_o | output | $clog2(N_SRC) | Index of the offered source |
| active_o | output | N_SRC | Active-level bits, one per source |
| pend_o | output | N_SRC | Latched pending requests |

## Verification
The assertions rely on the core following the handshake. They assume `ack_i` is pulsed only while `irq_req_o` is high, `rti_i` never shares a cycle with an acknowledge, and source lines stay low during reset. The stimulus tasks respect all three. Each task drives a single-cycle acknowledge or return pulse only after it has checked that a request is showing or a routine is active. Every task ends with all routines returned and the source lines low.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  localparam int MAX_SRC = 32;

  // Bit i is set when no bit at index <= i is set in act, that is,
  // source i is more urgent than every active level.
  function automatic logic [MAX_SRC-1:0] above_all(input logic [MAX_SRC-1:0] act);
    logic [MAX_SRC-1:0] res;
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < MAX_SRC; i++) begin
      seen   = seen | act[i];
      res[i] = ~seen;
    end
    return res;
  endfunction
endpackage

// File: rtl/nir_edge_latch.sv
module nir_edge_latch #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] rise;

  assign rise = src_i & ~src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      pend_o <= '0;
    end else begin
      src_q  <= src_i;
      pend_o <= (pend_o & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/nir_pick.sv
module nir_pick #(
  parameter int N_SRC = 8,
  localparam int W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] umask_i,
  input  logic [N_SRC-1:0] active_i,
  input  logic             nest_en_i,
  output logic             any_o,
  output logic [W-1:0]     idx_o
);
  import nest_irq_pkg::*;

  logic [MAX_SRC-1:0] act_w;
  logic [MAX_SRC-1:0] above_w;
  logic [N_SRC-1:0]   gate;
  logic [N_SRC-1:0]   elig;

  always_comb begin
    act_w = '0;
    act_w[N_SRC-1:0] = active_i;
  end

  assign above_w = above_all(act_w);
  assign gate    = nest_en_i ? above_w[N_SRC-1:0]
                             : ((|active_i) ? '0 : {N_SRC{1'b1}});
  assign elig    = pend_i & umask_i & gate;
  assign any_o   = |elig;

  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/nir_level_track.sv
module nir_level_track #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_i,
  input  logic             rti_i,
  output logic [N_SRC-1:0] active_o
);
  logic [N_SRC-1:0] innermost;

  // isolate lowest set bit; zero when nothing is active
  assign innermost = active_o & ~(active_o - N_SRC'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= '0;
    end else begin
      active_o <= (active_o & ~(rti_i ? innermost : '0)) | set_i;
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int N_SRC = 8,
  localparam int W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] umask_i,
  input  logic             nest_en_i,
  input  logic             ack_i,
  input  logic             rti_i,
  output logic             irq_req_o,
  output logic [W-1:0]     irq_vec_o,
  output logic [N_SRC-1:0] active_o,
  output logic [N_SRC-1:0] pend_o
);
  logic             take;
  logic [N_SRC-1:0] take_oh;
  logic             any;
  logic [W-1:0]     idx;

  assign take    = irq_req_o & ack_i;
  assign take_oh = take ? (N_SRC'(1) << irq_vec_o) : '0;

  nir_edge_latch #(.N_SRC(N_SRC)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .src_i  (src_i),
    .clr_i  (take_oh),
    .pend_o (pend_o)
  );

  nir_pick #(.N_SRC(N_SRC)) u_pick (
    .pend_i    (pend_o),
    .umask_i   (umask_i),
    .active_i  (active_o),
    .nest_en_i (nest_en_i),
    .any_o     (any),
    .idx_o     (idx)
  );

  nir_level_track #(.N_SRC(N_SRC)) u_levels (
    .clk      (clk),
    .rst      (rst),
    .set_i    (take_oh),
    .rti_i    (rti_i),
    .active_o (active_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req_o <= 1'b0;
      irq_vec_o <= '0;
    end else if (irq_req_o) begin
      if (ack_i) irq_req_o <= 1'b0;
    end else if (any) begin
      irq_req_o <= 1'b1;
      irq_vec_o <= idx;
    end
  end
endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk #(
  parameter int N_SRC = 8,
  localparam int W = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst,
  input logic             nest_en_i,
  input logic             ack_i,
  input logic             rti_i,
  input logic             irq_req_o,
  input logic [W-1:0]     irq_vec_o,
  input logic [N_SRC-1:0] active_o,
  input logic [N_SRC-1:0] pend_o
);
  import nest_irq_pkg::*;

  logic [N_SRC-1:0]   vec_oh;
  logic [MAX_SRC-1:0] act_w;
  logic [MAX_SRC-1:0] above_w;

  assign vec_oh = N_SRC'(1) << irq_vec_o;
  always_comb begin
    act_w = '0;
    act_w[N_SRC-1:0] = active_o;
  end
  assign above_w = above_all(act_w);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_req_o && active_o == '0 && pend_o == '0));

  a_r2_offer_is_pending: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> ((pend_o & vec_oh) != '0));

  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_req_o && !ack_i) |=> (irq_req_o && $stable(irq_vec_o)));

  a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_req_o && ack_i) |=> !irq_req_o);

  a_r6_level_set: assert property (@(posedge clk) disable iff (rst)
    (irq_req_o && ack_i && !rti_i) |=> ((active_o & $past(vec_oh)) != '0));

  a_r7_beats_active: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req_o) |-> above_w[irq_vec_o]);

  a_r8_no_nest_when_off: assert property (@(posedge clk) disable iff (rst)
    (!nest_en_i && active_o != '0 && !irq_req_o) |=> !irq_req_o);

  a_r9_idle_return: assert property (@(posedge clk) disable iff (rst)
    (rti_i && active_o == '0 && !(irq_req_o && ack_i)) |=> (active_o == '0));
endmodule

bind nest_irq_ctrl nest_irq_chk #(.N_SRC(N_SRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .nest_en_i (nest_en_i),
  .ack_i     (ack_i),
  .rti_i     (rti_i),
  .irq_req_o (irq_req_o),
  .irq_vec_o (irq_vec_o),
  .active_o  (active_o),
  .pend_o    (pend_o)
);

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
  localparam int N = 8;
  localparam int W = $clog2(N);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src = '0;
  logic [N-1:0] umask = '0;
  logic         nest_en = 1'b1;
  logic         ack = 1'b0;
  logic         rti = 1'b0;
  logic         req;
  logic [W-1:0] vec;
  logic [N-1:0] active;
  logic [N-1:0] pend;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  nest_irq_ctrl #(.N_SRC(N)) u_nest_irq_ctrl (
    .clk(clk), .rst(rst), .src_i(src), .umask_i(umask), .nest_en_i(nest_en),
    .ack_i(ack), .rti_i(rti), .irq_req_o(req), .irq_vec_o(vec),
    .active_o(active), .pend_o(pend)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fire(input int k);
    src[k] = 1'b0; step();
    src[k] = 1'b1; step();
    src[k] = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic do_rti();
    rti = 1'b1; step(); rti = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 req", {31'd0, req}, 32'd0);
    check("R1 active", {24'd0, active}, 32'd0);
    check("R1 pend", {24'd0, pend}, 32'd0);
  endtask

  task automatic t_main();
    umask = '0; nest_en = 1'b1;
    fire(2);
    check("R2 latched", {24'd0, pend}, 32'h04);
    step(); step();
    check("R3 masked no req", {31'd0, req}, 32'd0);
    check("R3 still pending", {24'd0, pend}, 32'h04);
    fire(2);
    check("R2 no double", {24'd0, pend}, 32'h04);
    umask = '1; step();
    check("R5 req up", {31'd0, req}, 32'd1);
    check("R5 vec", {29'd0, vec}, 32'd2);
    fire(1);
    check("R5 held req", {31'd0, req}, 32'd1);
    check("R5 held vec", {29'd0, vec}, 32'd2);
    do_ack();
    check("R5 drop", {31'd0, req}, 32'd0);
    check("R6 active", {24'd0, active}, 32'h04);
    check("R6 pend cleared", {24'd0, pend}, 32'h02);
    step();
    check("R7 preempt req", {31'd0, req}, 32'd1);
    check("R7 preempt vec", {29'd0, vec}, 32'd1);
    do_ack();
    check("R6 two levels", {24'd0, active}, 32'h06);
    do_rti();
    check("R9 innermost", {24'd0, active}, 32'h04);
    do_rti();
    check("R9 last", {24'd0, active}, 32'h00);
    do_rti();
    check("R9 idle return", {24'd0, active}, 32'h00);
    check("R9 no req", {31'd0, req}, 32'd0);
    // held level must not re-latch after service
    src[4] = 1'b1; step(); step();
    check("R2 level edge", {24'd0, pend}, 32'h10);
    step();
    check("R4 single vec", {29'd0, vec}, 32'd4);
    do_ack();
    step(); step(); step();
    check("R2 held no relatch", {24'd0, pend}, 32'h00);
    check("R2 held no req", {31'd0, req}, 32'd0);
    do_rti();
    src[4] = 1'b0; step();
  endtask

  task automatic t_nest_off();
    nest_en = 1'b0;
    fire(5); step();
    check("R8 base vec", {29'd0, vec}, 32'd5);
    do_ack();
    fire(0);
    step(); step();
    check("R8 blocked", {31'd0, req}, 32'd0);
    check("R8 pending kept", {24'd0, pend}, 32'h01);
    do_rti();
    check("R8 not yet", {31'd0, req}, 32'd0);
    step();
    check("R10 released req", {31'd0, req}, 32'd1);
    check("R10 released vec", {29'd0, vec}, 32'd0);
    do_ack(); do_rti();
    nest_en = 1'b1;
  endtask

  task automatic t_lower_waits();
    nest_en = 1'b1;
    fire(3); step();
    check("R4 vec3", {29'd0, vec}, 32'd3);
    do_ack();
    fire(3); fire(6);
    check("R10 both latched", {24'd0, pend}, 32'h48);
    step(); step();
    check("R7 equal/lower blocked", {31'd0, req}, 32'd0);
    fire(1); step();
    check("R7 nest vec1", {29'd0, vec}, 32'd1);
    do_ack();
    check("R6 levels", {24'd0, active}, 32'h0A);
    do_rti();
    check("R9 inner gone", {24'd0, active}, 32'h08);
    step();
    check("R10 still waiting", {31'd0, req}, 32'd0);
    do_rti(); step();
    check("R10 first vec3", {29'd0, vec}, 32'd3);
    do_ack();
    step();
    check("R7 vec6 below active", {31'd0, req}, 32'd0);
    do_rti(); step();
    check("R10 then vec6", {29'd0, vec}, 32'd6);
    do_ack(); do_rti();
  endtask

  task automatic t_simul();
    src[4] = 1'b1; src[7] = 1'b1; step();
    src[4] = 1'b0; src[7] = 1'b0; step();
    check("R4 both pending", {24'd0, pend}, 32'h90);
    check("R4 req", {31'd0, req}, 32'd1);
    check("R4 lowest wins", {29'd0, vec}, 32'd4);
    do_ack(); do_rti(); step();
    check("R4 next vec7", {29'd0, vec}, 32'd7);
    do_ack(); do_rti();
    // user mask holds back the more urgent source
    umask = 8'hFE;
    src[0] = 1'b1; src[2] = 1'b1; step();
    src[0] = 1'b0; src[2] = 1'b0; step();
    check("R3 masked skipped", {29'd0, vec}, 32'd2);
    do_ack(); do_rti(); step();
    check("R3 masked waits", {31'd0, req}, 32'd0);
    check("R3 masked pending", {24'd0, pend}, 32'h01);
    umask = '1; step();
    check("R3 unmasked", {29'd0, vec}, 32'd0);
    do_ack(); do_rti();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_main();
    t_nest_off();
    t_lower_waits();
    t_simul();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule